// File: doc/BRIEF.md
# Serial Configuration Port with Hold-Controlled Transfer

This block is the write-only programming port of a pixel clock generator. A 56-bit configuration word is clocked in one bit at a time on a data pin, using a dedicated data clock. A second input, the hold level, is sampled on the same rising edge as each data bit. While it is low the shifted bits only fill a staging register and the settings already in use stay put. On an edge where it is high, the staging contents, including the bit taken on that edge, become the active configuration.

The active configuration is split into fields for the neighbouring divider and output blocks. These are the pixel divider code, the post-scaler/test select pair, the reference bypass select, the static test level, the enable polarity, the pixel divider disable, the feedback and reference divider values, the double-modulus bit and the reference edge select. Two moduli are also computed from the divider fields and supplied ready to use. The loop gain settings pass through as raw fields. A synchronous reset loads defaults that select divide-by-4 and route the reference clock to the pixel divider, so downstream logic works before the first write.

Top module: `pxcfg_serial_port`

## Requirements
- R1: On each rising edge of `clk_i` the level on `sdata_i` enters the staging register; of 56 consecutive bits the first becomes word bit 1 and the last becomes word bit 56 (positions below are 1-based).
- R2: An edge on which `hold_i` is low leaves the active word, and therefore every output, unchanged.
- R3: An edge on which `hold_i` is high copies the staging contents, including that edge's bit, into the active word; outputs show it right after that edge, also when fewer than 56 bits have been shifted since the last load.
- R4: While `rst_i` is high at a rising edge, the active word takes its defaults and the staging register clears: `pix_code_o` = 4'b0001 (divide-by-4 code), `ref_sel_o` = 1, all other field outputs 0, so `fb_mod_o` = 7 and `ref_mod_o` = 1. `hold_i` has no effect during reset.
- R5: Field positions: pixel code bits 1–4, post select bits 13–14, reference select bit 8, test level bit 16, enable polarity bit 39, pixel disable bit 46, reference edge bit 56; for every multi-bit field the lowest position is its LSB.
- R6: Divider fields: M bits 33–38, double bit 40, A bits 41–44, R bits 49–55, each with its LSB at the lowest position.
- R7: `fb_mod_o` = (M+1)·7 when A = 0, else (M+1)·6 + A; the result is doubled when the double bit is 1.
- R8: `ref_mod_o` = R + 1.
- R9: `aux_mode_o` is 1 exactly when bits 13 and 14 are both 1.
- R10: `vco_gain_o` is bits 25–27 (bit 25 LSB); `pd_gain_o` is {bit 32, bit 30, bit 29}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data clock; all sampling on its rising edge |
| rst_i | input | 1 | Synchronous reset to defaults |
| sdata_i | input | 1 | Serial data bit |
| hold_i | input | 1 | Transfer level, sampled with each bit |
| pix_code_o | output | 4 | Pixel divider code |
| post_sel_o | output | 2 | Post-scaler / test select |
| aux_mode_o | output | 1 | Static test level mode active |
| ref_sel_o | output | 1 | Route reference clock to pixel divider |
| aux_level_o | output | 1 | Static pixel output level in test mode |
| en_pol_o | output | 1 | Pixel enable polarity |
| pix_dis_o | output | 1 | Pixel divider disable |
| m_val_o | output | 6 | Feedback M field |
| dbl_o | output | 1 | Double feedback modulus |
| a_val_o | output | 4 | Feedback A field |
| r_val_o | output | 7 | Reference divider field |
| ref_edge_o | output | 1 | Reference edge select |
| vco_gain_o | output | 3 | Raw oscillator gain field |
| pd_gain_o | output | 3 | Raw phase detector gain field |
| fb_mod_o | output | 10 | Effective feedback modulus |
| ref_mod_o | output | 8 | Effective reference modulus |

## Verification
The bench goes after bit order: a lone 1 shifted first or last must land in bit 1 or bit 56. A reversed shifter would swap the pixel code and reference edge outputs. Long hold-low streams must leave outputs frozen; a design that loads every edge would show the streaming bits. Hold raised mid-stream checks that the transfer takes the bit of the same edge and a partly filled, reset-cleared staging register. A design off by one edge would be off by one bit position. The moduli are driven to their extremes (A = 0, M = 63, double set, R = 127), where a narrow result or a missed A = 0 case gives a wrong value.

// File: rtl/pxcfg_pkg.sv
package pxcfg_pkg;

    localparam int WORD_W = 56;

    // zero-based field positions (1-based position minus one)
    localparam int POS_PIX    = 0;
    localparam int PIX_W      = 4;
    localparam int POS_REFSEL = 7;
    localparam int POS_SEL    = 12;
    localparam int SEL_W      = 2;
    localparam int POS_AUX    = 15;
    localparam int POS_VCO    = 24;
    localparam int VCO_W      = 3;
    localparam int POS_PD_LO  = 28;
    localparam int POS_PD_HI  = 31;
    localparam int PD_W       = 3;
    localparam int POS_M      = 32;
    localparam int M_W        = 6;
    localparam int POS_POL    = 38;
    localparam int POS_DBL    = 39;
    localparam int POS_A      = 40;
    localparam int A_W        = 4;
    localparam int POS_DIS    = 45;
    localparam int POS_R      = 48;
    localparam int R_W        = 7;
    localparam int POS_EDGE   = 55;

    // modulus widths: (2^M_W)*7*2 and 2^R_W need these
    localparam int FB_W = M_W + 4;
    localparam int RM_W = R_W + 1;

    // defaults: divide-by-4 code, reference bypass on, fixed-one positions 7,10,28,45
    localparam logic [WORD_W-1:0] WORD_RST =
          (WORD_W'(1) << 0)
        | (WORD_W'(1) << 6)
        | (WORD_W'(1) << POS_REFSEL)
        | (WORD_W'(1) << 9)
        | (WORD_W'(1) << 27)
        | (WORD_W'(1) << 44);

    typedef struct packed {
        logic [PIX_W-1:0] pix_code;
        logic [SEL_W-1:0] post_sel;
        logic             aux_mode;
        logic             ref_sel;
        logic             aux_level;
        logic             en_pol;
        logic             pix_dis;
        logic [M_W-1:0]   m_val;
        logic             dbl;
        logic [A_W-1:0]   a_val;
        logic [R_W-1:0]   r_val;
        logic             ref_edge;
        logic [VCO_W-1:0] vco_gain;
        logic [PD_W-1:0]  pd_gain;
        logic [FB_W-1:0]  fb_mod;
        logic [RM_W-1:0]  ref_mod;
    } cfg_fields_t;

endpackage

// File: rtl/pxcfg_shift.sv
module pxcfg_shift #(
    parameter int W = 56
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         sdata_i,
    output logic [W-1:0] next_o
);

    typedef struct packed {
        logic [W-1:0] sr;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d    = state_q;
        state_d.sr = {sdata_i, state_q.sr[W-1:1]};
        if (rst_i) begin
            state_d.sr = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    // value the staging register takes at this edge, offered for transfer
    assign next_o = {sdata_i, state_q.sr[W-1:1]};

    // R1
    shift_in_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> state_q.sr[W-1] == $past(sdata_i));

    // R1
    shift_move_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> state_q.sr[W-2:0] == $past(state_q.sr[W-1:1]));

endmodule

// File: rtl/pxcfg_active.sv
module pxcfg_active #(
    parameter int           W       = 56,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         hold_i,
    input  logic [W-1:0] load_word_i,
    output logic [W-1:0] word_o
);

    typedef struct packed {
        logic [W-1:0] word;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rst_i) begin
            state_d.word = RST_VAL;
        end else if (hold_i) begin
            state_d.word = load_word_i;
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign word_o = state_q.word;

    // R2
    hold_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !hold_i |=> $stable(state_q.word));

    // R3
    hold_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        hold_i |=> state_q.word == $past(load_word_i));

    // R4
    rst_dflt_chk: assert property (@(posedge clk_i)
        $past(rst_i) |-> state_q.word == RST_VAL);

endmodule

// File: rtl/pxcfg_decode.sv
module pxcfg_decode
    import pxcfg_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output cfg_fields_t       fields_o
);

    logic [M_W-1:0]  m_val;
    logic [A_W-1:0]  a_val;
    logic [FB_W-1:0] m_plus;
    logic [FB_W-1:0] fb_base;
    logic            unused_bits;

    assign unused_bits = ^word_i;

    always_comb begin
        m_val  = word_i[POS_M +: M_W];
        a_val  = word_i[POS_A +: A_W];
        m_plus = FB_W'(m_val) + FB_W'(1);
        if (a_val == '0) begin
            fb_base = m_plus * FB_W'(7);
        end else begin
            fb_base = m_plus * FB_W'(6) + FB_W'(a_val);
        end

        fields_o.pix_code  = word_i[POS_PIX +: PIX_W];
        fields_o.post_sel  = word_i[POS_SEL +: SEL_W];
        fields_o.aux_mode  = &word_i[POS_SEL +: SEL_W];
        fields_o.ref_sel   = word_i[POS_REFSEL];
        fields_o.aux_level = word_i[POS_AUX];
        fields_o.en_pol    = word_i[POS_POL];
        fields_o.pix_dis   = word_i[POS_DIS];
        fields_o.m_val     = m_val;
        fields_o.dbl       = word_i[POS_DBL];
        fields_o.a_val     = a_val;
        fields_o.r_val     = word_i[POS_R +: R_W];
        fields_o.ref_edge  = word_i[POS_EDGE];
        fields_o.vco_gain  = word_i[POS_VCO +: VCO_W];
        fields_o.pd_gain   = {word_i[POS_PD_HI], word_i[POS_PD_LO +: 2]};
        fields_o.fb_mod    = word_i[POS_DBL] ? (fb_base << 1) : fb_base;
        fields_o.ref_mod   = RM_W'(word_i[POS_R +: R_W]) + RM_W'(1);
    end

endmodule

// File: rtl/pxcfg_serial_port.sv
module pxcfg_serial_port
    import pxcfg_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             sdata_i,
    input  logic             hold_i,
    output logic [PIX_W-1:0] pix_code_o,
    output logic [SEL_W-1:0] post_sel_o,
    output logic             aux_mode_o,
    output logic             ref_sel_o,
    output logic             aux_level_o,
    output logic             en_pol_o,
    output logic             pix_dis_o,
    output logic [M_W-1:0]   m_val_o,
    output logic             dbl_o,
    output logic [A_W-1:0]   a_val_o,
    output logic [R_W-1:0]   r_val_o,
    output logic             ref_edge_o,
    output logic [VCO_W-1:0] vco_gain_o,
    output logic [PD_W-1:0]  pd_gain_o,
    output logic [FB_W-1:0]  fb_mod_o,
    output logic [RM_W-1:0]  ref_mod_o
);

    logic [WORD_W-1:0] stage_next;
    logic [WORD_W-1:0] active_word;
    cfg_fields_t       fields;

    pxcfg_shift #(.W(WORD_W)) shift_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .sdata_i (sdata_i),
        .next_o  (stage_next)
    );

    pxcfg_active #(.W(WORD_W), .RST_VAL(WORD_RST)) active_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .hold_i      (hold_i),
        .load_word_i (stage_next),
        .word_o      (active_word)
    );

    pxcfg_decode decode_i (
        .word_i   (active_word),
        .fields_o (fields)
    );

    assign pix_code_o  = fields.pix_code;
    assign post_sel_o  = fields.post_sel;
    assign aux_mode_o  = fields.aux_mode;
    assign ref_sel_o   = fields.ref_sel;
    assign aux_level_o = fields.aux_level;
    assign en_pol_o    = fields.en_pol;
    assign pix_dis_o   = fields.pix_dis;
    assign m_val_o     = fields.m_val;
    assign dbl_o       = fields.dbl;
    assign a_val_o     = fields.a_val;
    assign r_val_o     = fields.r_val;
    assign ref_edge_o  = fields.ref_edge;
    assign vco_gain_o  = fields.vco_gain;
    assign pd_gain_o   = fields.pd_gain;
    assign fb_mod_o    = fields.fb_mod;
    assign ref_mod_o   = fields.ref_mod;

endmodule

// File: tb/pxcfg_serial_port_tb_top.sv
`timescale 1ns/1ps
module pxcfg_serial_port_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sdata = 1'b0;
    logic       hold = 1'b0;
    logic [3:0] pix_code;
    logic [1:0] post_sel;
    logic       aux_mode, ref_sel, aux_level, en_pol, pix_dis, dbl, ref_edge;
    logic [5:0] m_val;
    logic [3:0] a_val;
    logic [6:0] r_val;
    logic [2:0] vco_gain, pd_gain;
    logic [9:0] fb_mod;
    logic [7:0] ref_mod;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [55:0] m_sr;
    logic [55:0] m_act;
    localparam logic [55:0] DFLT = 56'h0000_1000_0800_02C1;

    always #2.5 clk = ~clk;

    pxcfg_serial_port dut_i (
        .clk_i(clk), .rst_i(rst), .sdata_i(sdata), .hold_i(hold),
        .pix_code_o(pix_code), .post_sel_o(post_sel), .aux_mode_o(aux_mode),
        .ref_sel_o(ref_sel), .aux_level_o(aux_level), .en_pol_o(en_pol),
        .pix_dis_o(pix_dis), .m_val_o(m_val), .dbl_o(dbl), .a_val_o(a_val),
        .r_val_o(r_val), .ref_edge_o(ref_edge), .vco_gain_o(vco_gain),
        .pd_gain_o(pd_gain), .fb_mod_o(fb_mod), .ref_mod_o(ref_mod)
    );

    // 1-based field extraction
    function automatic int fld(logic [55:0] w, int pos1, int width);
        int v = 0;
        for (int i = 0; i < width; i++) v |= int'(w[pos1 - 1 + i]) << i;
        return v;
    endfunction

    function automatic int exp_fb(logic [55:0] w);
        int m = fld(w, 33, 6);
        int a = fld(w, 41, 4);
        int n = (a == 0) ? (m + 1) * 7 : (m + 1) * 6 + a;
        return w[39] ? 2 * n : n;
    endfunction

    task automatic chk(string req, int act, int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic check_all(string ctx, logic [55:0] w);
        chk({ctx, " R5 pix_code"},  int'(pix_code),  fld(w, 1, 4));
        chk({ctx, " R5 post_sel"},  int'(post_sel),  fld(w, 13, 2));
        chk({ctx, " R5 ref_sel"},   int'(ref_sel),   fld(w, 8, 1));
        chk({ctx, " R5 aux_level"}, int'(aux_level), fld(w, 16, 1));
        chk({ctx, " R5 en_pol"},    int'(en_pol),    fld(w, 39, 1));
        chk({ctx, " R5 pix_dis"},   int'(pix_dis),   fld(w, 46, 1));
        chk({ctx, " R5 ref_edge"},  int'(ref_edge),  fld(w, 56, 1));
        chk({ctx, " R6 m_val"},     int'(m_val),     fld(w, 33, 6));
        chk({ctx, " R6 dbl"},       int'(dbl),       fld(w, 40, 1));
        chk({ctx, " R6 a_val"},     int'(a_val),     fld(w, 41, 4));
        chk({ctx, " R6 r_val"},     int'(r_val),     fld(w, 49, 7));
        chk({ctx, " R7 fb_mod"},    int'(fb_mod),    exp_fb(w));
        chk({ctx, " R8 ref_mod"},   int'(ref_mod),   fld(w, 49, 7) + 1);
        chk({ctx, " R9 aux_mode"},  int'(aux_mode),  int'(fld(w, 13, 2) == 3));
        chk({ctx, " R10 vco_gain"}, int'(vco_gain),  fld(w, 25, 3));
        chk({ctx, " R10 pd_gain"},  int'(pd_gain),
            (fld(w, 32, 1) << 2) | fld(w, 29, 2));
    endtask

    // drive at negedge, model the edge, return at next negedge
    task automatic clk_bit(logic b, logic h);
        sdata = b;
        hold  = h;
        @(posedge clk);
        if (rst) begin
            m_sr  = '0;
            m_act = DFLT;
        end else begin
            m_sr = {b, m_sr[55:1]};
            if (h) m_act = m_sr;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        for (int i = 0; i < 3; i++) clk_bit(1'($urandom_range(0, 1)), 1'b1);
        rst = 1'b0;
        hold = 1'b0;
    endtask

    task automatic write_word(logic [55:0] w);
        for (int i = 0; i < 56; i++) clk_bit(w[i], logic'(i == 55));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [55:0] w;
        logic [55:0] snap;
        void'($urandom(32'h1574_0a5e));
        m_sr = '0;
        m_act = DFLT;
        @(negedge clk);
        do_reset();

        // R4 reset defaults
        chk("R4 pix_code default", int'(pix_code), 1);
        chk("R4 ref_sel default",  int'(ref_sel), 1);
        chk("R4 fb_mod default",   int'(fb_mod), 7);
        chk("R4 ref_mod default",  int'(ref_mod), 1);
        check_all("R4 defaults", DFLT);

        // R1 first bit lands in bit 1, last in bit 56
        write_word(56'h1);
        chk("R1 first bit to pos1", int'(pix_code), 1);
        chk("R1 first bit not pos56", int'(ref_edge), 0);
        write_word(56'h80_0000_0000_0000);
        chk("R1 last bit to pos56", int'(ref_edge), 1);
        chk("R1 last bit not pos1", int'(pix_code), 0);

        // R7 R8 extremes
        w = '0;
        w[37:32] = 6'd63; w[39] = 1'b1; w[43:40] = 4'd0; w[54:48] = 7'd127;
        write_word(w);
        chk("R7 A=0 M=63 dbl", int'(fb_mod), 896);
        chk("R8 R=127", int'(ref_mod), 128);
        w[43:40] = 4'd15; w[39] = 1'b0; w[37:32] = 6'd0;
        write_word(w);
        chk("R7 A=15 M=0", int'(fb_mod), 21);
        w[13:12] = 2'b11; w[15] = 1'b1;
        write_word(w);
        chk("R9 aux mode on", int'(aux_mode), 1);
        check_all("R9 word", m_act);

        // R2 long hold-low stream
        snap = m_act;
        for (int i = 0; i < 120; i++) clk_bit(1'($urandom_range(0, 1)), 1'b0);
        check_all("R2 frozen", snap);

        // R3 mid-stream load after reset clears staging
        do_reset();
        for (int i = 0; i < 9; i++) clk_bit(1'b1, 1'b0);
        clk_bit(1'b1, 1'b1);
        chk("R3 partial ref_edge", int'(ref_edge), 1);
        chk("R3 partial pix_code", int'(pix_code), 0);
        check_all("R3 partial", m_act);

        // R4 reset mid-stream with hold high
        for (int i = 0; i < 20; i++) clk_bit(1'($urandom_range(0, 1)), 1'b0);
        do_reset();
        check_all("R4 mid reset", DFLT);

        // random traffic, R1 R2 R3 via model
        for (int i = 0; i < 3000; i++) begin
            clk_bit(1'($urandom_range(0, 1)), logic'($urandom_range(0, 19) == 0));
            if (i % 7 == 0) check_all("R3 random", m_act);
        end
        for (int k = 0; k < 20; k++) begin
            w = {$urandom(), $urandom()};
            write_word(w);
            check_all("R3 full word", w);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule